// File: doc/BRIEF.md
# Audio Sample Input FIFO Stage

This block is the write side of a sampling rate converter. A bus master writes 32-bit words to a data register. Each accepted word goes into a 16-entry sample FIFO. The register itself cannot be read back: a read always returns zero. When the FIFO already holds 16 words, a write is dropped, unless a pop happens in the same cycle.

The converter core draws samples through a pop port. On each accepted pop, the oldest word is split into a channel 0 sample and a channel 1 sample. Two control inputs, sampled at the moment of the pop, shape the output:

- A swap input exchanges the two bytes inside each 16-bit sample.
- A mono input marks the lower half of the word as carrying no sample.

A pop on an empty FIFO is ignored. The outputs then keep their last values and the valid flags stay low.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| OCC_EMPTY | No words held |
| OCC_PART | Between 1 and 15 words held |
| OCC_FULL | 16 words held |

| Transition | From | To | Condition |
|---|---|---|---|
| first-fill | OCC_EMPTY | OCC_PART | A push is accepted |
| last-drain | OCC_PART | OCC_EMPTY | A pop takes the only word, with no push |
| top-off | OCC_PART | OCC_FULL | A push brings the count to 16, with no pop |
| release | OCC_FULL | OCC_PART | A pop without a push |
| full-exchange | OCC_FULL | OCC_FULL | A push and a pop in the same cycle |

Top module: `smp_in_stage`

## Requirements
- R1: After reset:
  - `fifo_count` is 0 and `fifo_full` is 0.
  - `smp_valid` and `ch1_valid` are 0.
  - `ch0_smp` and `ch1_smp` are 0.
- R2: Words leave the FIFO in the order they were written. `fifo_count` gives the number of words held, from 0 to 16. It updates on the clock edge that accepts the push or pop.
- R3: `fifo_full` is 1 exactly when `fifo_count` equals 16.
- R4: While 16 words are held, a write without a pop changes neither the count nor the FIFO contents. The dropped word never appears at the pop port.
- R5: `bus_rdata` is 0 on all 32 bits at all times.
- R6: In stereo mode (`mono_mode`=0) with `swap_en`=0, a popped word w gives:
  - `ch0_smp` = w[31:16]
  - `ch1_smp` = w[15:0]
  - `ch1_valid` = 1
- R7: With `swap_en`=1, a popped word w gives `ch0_smp` = {w[23:16], w[31:24]}. In stereo mode it also gives `ch1_smp` = {w[7:0], w[15:8]}.
- R8: In mono mode (`mono_mode`=1), a popped word gives:
  - `ch0_smp` from w[31:16], with the R6 or R7 byte order
  - `ch1_smp` = 0
  - `ch1_valid` = 0
- R9: `swap_en` and `mono_mode` are applied in the cycle of the pop. The values they had when the word was written do not matter.
- R10: With 16 words held, a write together with a pop is accepted and `fifo_count` stays 16. The written word is popped after the 15 words that were older than it.
- R11: A pop while the FIFO is empty leaves `smp_valid` and `ch1_valid` at 0 and keeps `ch0_smp` and `ch1_smp` unchanged. A write in the same cycle is still accepted.
- R12: `smp_valid` is 1 for exactly one cycle, in the cycle after each accepted pop. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the data register |
| bus_wdata | input | 32 | Word to write into the FIFO |
| bus_rdata | output | 32 | Data register read value, always zero |
| swap_en | input | 1 | 1 = swap the two bytes inside each sample at pop time |
| mono_mode | input | 1 | 1 = mono, lower half discarded; 0 = stereo |
| fifo_count | output | 5 | Number of words held (0 to 16) |
| fifo_full | output | 1 | 1 when 16 words are held |
| pop | input | 1 | Pop request from the converter core |
| ch0_smp | output | 16 | Channel 0 sample from the last accepted pop |
| ch1_smp | output | 16 | Channel 1 sample from the last accepted pop |
| smp_valid | output | 1 | One-cycle pulse after an accepted pop |
| ch1_valid | output | 1 | Channel 1 sample valid with this pulse |

## Verification
The bound checker asserts, on every cycle:
- the zero read value;
- the tie between `fifo_full` and `fifo_count`;
- the count bound;
- that a write into a full FIFO without a pop leaves the count unchanged;
- that a push and a pop together on a full FIFO keep it full;
- that an empty pop produces no pulse and holds the samples;
- the mono output shape;
- that `smp_valid` pulses only after a pop.

Some behaviour only the bench's scenarios can show. These are word order through a full wrap, the exact byte lanes under each swap setting, and the fact that control is applied at pop time rather than write time. The bench also shows that a dropped word never comes out. It checks these against a reference queue of the words written.

// File: rtl/smpin_pkg.sv
package smpin_pkg;

    // Occupancy classes of the sample FIFO.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

endpackage

// File: rtl/smpin_fifo_ctrl.sv
module smpin_fifo_ctrl
    import smpin_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          full
);

    occ_e          state_q;
    occ_e          state_d;
    logic [CW-1:0] count_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;

    // Accepted operations: a pop frees a slot in the same cycle.
    always_comb begin
        pop_ok  = pop_req && (state_q != OCC_EMPTY);
        push_ok = wr_req  && ((state_q != OCC_FULL) || pop_req);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                // first-fill
                if (push_ok) begin
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PART;
                end
            end
            OCC_PART: begin
                // top-off
                if (push_ok && !pop_ok && (count_q == CW'(DEPTH - 1))) begin
                    state_d = OCC_FULL;
                end
                // last-drain
                else if (pop_ok && !push_ok && (count_q == CW'(1))) begin
                    state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                // release; full-exchange keeps the state
                if (pop_ok && !push_ok) begin
                    state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PART;
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Count and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
            if (push_ok) begin
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
            end
            if (pop_ok) begin
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
            end
        end
    end

    // Outputs.
    always_comb begin
        wr_ptr = wptr_q;
        rd_ptr = rptr_q;
        count  = count_q;
        full   = (state_q == OCC_FULL);
    end

endmodule

// File: rtl/smpin_sample_mem.sv
module smpin_sample_mem #(
    parameter int DEPTH = 16,
    parameter int WORD_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/smpin_lane_unpack.sv
module smpin_lane_unpack #(
    parameter int SMP_W = 16,
    localparam int WORD_W = 2 * SMP_W,
    localparam int HB = SMP_W / 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              swap,
    input  logic              mono,
    output logic [SMP_W-1:0]  ch0,
    output logic [SMP_W-1:0]  ch1,
    output logic              ch1_ok
);

    logic [SMP_W-1:0] lane [2];

    // Lane 0 is the upper half of the word, lane 1 the lower half.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [SMP_W-1:0] raw;
        assign raw     = word[WORD_W - 1 - g * SMP_W -: SMP_W];
        assign lane[g] = swap ? {raw[HB-1:0], raw[SMP_W-1:HB]} : raw;
    end

    always_comb begin
        ch0    = lane[0];
        ch1    = mono ? '0 : lane[1];
        ch1_ok = !mono;
    end

endmodule

// File: rtl/smp_in_stage.sv
module smp_in_stage #(
    parameter int DEPTH = 16,
    parameter int SMP_W = 16,
    localparam int WORD_W = 2 * SMP_W,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              swap_en,
    input  logic              mono_mode,
    output logic [CW-1:0]     fifo_count,
    output logic              fifo_full,
    input  logic              pop,
    output logic [SMP_W-1:0]  ch0_smp,
    output logic [SMP_W-1:0]  ch1_smp,
    output logic              smp_valid,
    output logic              ch1_valid
);

    logic              push_ok;
    logic              pop_ok;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [WORD_W-1:0] head_word;
    logic [SMP_W-1:0]  u_ch0;
    logic [SMP_W-1:0]  u_ch1;
    logic              u_ch1_ok;

    smpin_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (bus_wr),
        .pop_req (pop),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (fifo_count),
        .full    (fifo_full)
    );

    smpin_sample_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (bus_wdata),
        .raddr (rd_ptr),
        .rdata (head_word)
    );

    // Control is applied to the head word in the cycle of the pop.
    smpin_lane_unpack #(.SMP_W(SMP_W)) u_unpack (
        .word   (head_word),
        .swap   (swap_en),
        .mono   (mono_mode),
        .ch0    (u_ch0),
        .ch1    (u_ch1),
        .ch1_ok (u_ch1_ok)
    );

    // Pop-port output register: samples hold between accepted pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch0_smp   <= '0;
            ch1_smp   <= '0;
            smp_valid <= 1'b0;
            ch1_valid <= 1'b0;
        end else begin
            smp_valid <= pop_ok;
            ch1_valid <= pop_ok && u_ch1_ok;
            if (pop_ok) begin
                ch0_smp <= u_ch0;
                ch1_smp <= u_ch1;
            end
        end
    end

    // The data register reads as zero.
    assign bus_rdata = '0;

endmodule

// File: rtl/smp_in_stage_chk.sv
module smp_in_stage_chk #(
    parameter int DEPTH = 16,
    parameter int SMP_W = 16,
    localparam int WORD_W = 2 * SMP_W,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              mono_mode,
    input logic [CW-1:0]     fifo_count,
    input logic              fifo_full,
    input logic              pop,
    input logic [SMP_W-1:0]  ch0_smp,
    input logic [SMP_W-1:0]  ch1_smp,
    input logic              smp_valid,
    input logic              ch1_valid
);

    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata == '0); // R5

    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full == (fifo_count == CW'(DEPTH))); // R3

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && bus_wr && !pop) |=> (fifo_count == $past(fifo_count))); // R4

    AST_FULL_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && bus_wr && pop) |=> fifo_full); // R10

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && pop) |=> (!smp_valid && $stable(ch0_smp) && $stable(ch1_smp))); // R11

    AST_MONO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_mode && pop && fifo_count != '0) |=> (smp_valid && !ch1_valid && ch1_smp == '0)); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> !smp_valid); // R12

    AST_CH1_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_valid |-> smp_valid); // R6

endmodule

bind smp_in_stage smp_in_stage_chk #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .mono_mode  (mono_mode),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .pop        (pop),
    .ch0_smp    (ch0_smp),
    .ch1_smp    (ch1_smp),
    .smp_valid  (smp_valid),
    .ch1_valid  (ch1_valid)
);

// File: tb/tb_smp_in_stage.sv
module tb_smp_in_stage;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        swap_en = 1'b0;
    logic        mono_mode = 1'b0;
    logic [4:0]  fifo_count;
    logic        fifo_full;
    logic        pop = 1'b0;
    logic [15:0] ch0_smp;
    logic [15:0] ch1_smp;
    logic        smp_valid;
    logic        ch1_valid;

    always #2 clk = ~clk;

    smp_in_stage dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .swap_en(swap_en), .mono_mode(mono_mode),
        .fifo_count(fifo_count), .fifo_full(fifo_full), .pop(pop),
        .ch0_smp(ch0_smp), .ch1_smp(ch1_smp), .smp_valid(smp_valid),
        .ch1_valid(ch1_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;

    logic [31:0] model_q[$];
    logic [15:0] exp0_q[$];
    logic [15:0] exp1_q[$];
    bit          expv_q[$];
    logic [15:0] last_ch0 = '0;
    logic [15:0] last_ch1 = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bsw(input logic [15:0] v, input bit s);
        return s ? {v[7:0], v[15:8]} : v;
    endfunction

    // Driver: one cycle of stimulus; the model is updated after the edge.
    task automatic step(input bit wr, input logic [31:0] d, input bit pp);
        bit pop_acc;
        bit push_acc;
        logic [31:0] w;
        bus_wr    = wr;
        bus_wdata = d;
        pop       = pp;
        pop_acc   = pp && (model_q.size() > 0);
        push_acc  = wr && ((model_q.size() < DEPTH) || pp);
        @(posedge clk);
        #1;
        if (pop_acc) begin
            w = model_q.pop_front();
            exp0_q.push_back(bsw(w[31:16], swap_en));
            exp1_q.push_back(mono_mode ? 16'h0 : bsw(w[15:0], swap_en));
            expv_q.push_back(!mono_mode);
        end
        if (push_acc) model_q.push_back(d);
        bus_wr = 1'b0;
        pop    = 1'b0;
    endtask

    // Monitor: compares results with the scoreboard away from the edge.
    always @(negedge clk) begin
        if (mon_on) begin
            chk(fifo_count == 5'(model_q.size()), "R2 count", 32'(fifo_count), 32'(model_q.size()));
            chk(fifo_full == (model_q.size() == DEPTH), "R3 full", 32'(fifo_full), 32'(model_q.size() == DEPTH));
            chk(bus_rdata == 32'h0, "R5 rdata", bus_rdata, 32'h0);
            if (smp_valid) begin
                if (exp0_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected valid", 32'(smp_valid), 32'h0);
                end else begin
                    logic [15:0] e0;
                    logic [15:0] e1;
                    bit          ev;
                    e0 = exp0_q.pop_front();
                    e1 = exp1_q.pop_front();
                    ev = expv_q.pop_front();
                    chk(ch0_smp == e0, "R6 R7 R9 ch0", 32'(ch0_smp), 32'(e0));
                    chk(ch1_smp == e1, "R6 R7 R8 ch1", 32'(ch1_smp), 32'(e1));
                    chk(ch1_valid == ev, "R8 ch1_valid", 32'(ch1_valid), 32'(ev));
                end
                last_ch0 = ch0_smp;
                last_ch1 = ch1_smp;
            end else begin
                chk(exp0_q.size() == 0, "R12 missing valid", 32'(smp_valid), 32'h1);
                chk(ch1_valid == 1'b0, "R12 ch1_valid outside pulse", 32'(ch1_valid), 32'h0);
            end
        end
    end

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fifo_count == 0, "R1 count", 32'(fifo_count), 0);
        chk(fifo_full == 0, "R1 full", 32'(fifo_full), 0);
        chk(!smp_valid && !ch1_valid, "R1 valid", {30'h0, smp_valid, ch1_valid}, 0);
        chk(ch0_smp == 0 && ch1_smp == 0, "R1 samples", {ch0_smp, ch1_smp}, 0);
        @(posedge clk);
        #1;
        mon_on = 1'b1;

        // R6 stereo, no swap, order
        step(1, 32'hA1B2_C3D4, 0);
        step(1, 32'h1122_3344, 0);
        step(1, 32'h5566_7788, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 0);

        // R7 swap in stereo
        swap_en = 1'b1;
        step(1, 32'h0102_0304, 0);
        step(1, 32'hF0E1_D2C3, 1);
        step(0, 0, 1);
        step(0, 0, 0);

        // R8 mono, with and without swap
        mono_mode = 1'b1;
        step(1, 32'hBEEF_CAFE, 0);
        step(0, 0, 1);
        swap_en = 1'b0;
        step(1, 32'h1234_5678, 0);
        step(0, 0, 1);
        step(0, 0, 0);
        chk(ch1_smp == 16'h0, "R8 ch1 zero", 32'(ch1_smp), 0);

        // R9 control applied at pop time
        mono_mode = 1'b0;
        step(1, 32'hAB12_CD34, 0);
        swap_en = 1'b1;
        mono_mode = 1'b1;
        step(0, 0, 1);
        swap_en = 1'b0;
        mono_mode = 1'b0;
        step(0, 0, 0);
        chk(ch0_smp == 16'h12AB, "R9 swap at pop", 32'(ch0_smp), 32'h12AB);

        // R3/R4/R10 fill to 16, drop, full exchange, drain
        for (int i = 0; i < DEPTH; i++) step(1, 32'h1000_0000 + 32'(i * 32'h0001_0101), 0);
        chk(fifo_full == 1'b1, "R3 full at 16", 32'(fifo_full), 1);
        step(1, 32'hDEAD_DEAD, 0);
        chk(fifo_count == 5'd16, "R4 dropped write", 32'(fifo_count), 16);
        step(1, 32'h7777_8888, 1);
        chk(fifo_count == 5'd16, "R10 push+pop at full", 32'(fifo_count), 16);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
        step(0, 0, 0);
        chk(ch0_smp == 16'h7777, "R10 exchanged word last", 32'(ch0_smp), 32'h7777);

        // R11 empty pop ignored, and empty pop with a write
        step(0, 0, 1);
        step(0, 0, 0);
        chk(ch0_smp == last_ch0 && ch1_smp == last_ch1, "R11 hold",
            {ch0_smp, ch1_smp}, {last_ch0, last_ch1});
        chk(smp_valid == 1'b0, "R11 no pulse", 32'(smp_valid), 0);
        step(1, 32'h4242_2424, 1);
        chk(fifo_count == 5'd1, "R11 write accepted", 32'(fifo_count), 1);
        step(0, 0, 1);
        step(0, 0, 0);

        // R12 back-to-back pops give back-to-back pulses
        step(1, 32'h0A0B_0C0D, 0);
        step(1, 32'h0E0F_1011, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 0);
        step(0, 0, 0);

        mon_on = 1'b0;
        chk(exp0_q.size() == 0, "R12 all pulses seen", 32'(exp0_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule